// File: doc/BRIEF.md
# Multi-Banked Shared Memory Arbiter

This block lets a set of bus masters share one on-chip memory that is split into independent banks. Each master has its own request port carrying a word address, a write flag, write data and byte enables. A mode input picks the address map at run time. In interleaved mode consecutive words fall in consecutive banks. In blocked mode each bank holds one contiguous region.

Each bank has its own round-robin arbiter. Masters that address different banks are all served in the same cycle. Masters that collide on one bank take turns. A granted write lands at the clock edge that ends the grant cycle. Read data comes back on the master's own return path one cycle after its grant, marked by a valid strobe. A master that is not granted keeps its request up until it is served.

Top module: `banked_mem_arbiter`

## Requirements
- R1: After reset every read-valid output is low, no grant is given while no request is raised, and every bank's round-robin pointer starts at master 0.
- R2: With mode_blocked low the bank index is word-address bits [3:0] and the row is bits [9:4]. For example, addresses 1 and 2 reach banks 1 and 2.
- R3: With mode_blocked high the bank index is word-address bits [9:6] and the row is bits [5:0]. The same physical word is reached by either map: interleaved address 19 and blocked address 193 are both bank 3, row 1.
- R4: A grant goes only to a master that is requesting, and each bank grants at most one master per cycle.
- R5: Each bank searches for a requester starting at the master after the last one it granted, wrapping from the highest master index back to 0.
- R6: Masters addressing distinct banks are all granted in the same cycle.
- R7: A granted read raises that master's m_rvalid in the next cycle, with the addressed word on its m_rdata. A granted write raises no m_rvalid.
- R8: On a write, byte lane i (m_wdata bits 8i+7..8i) is stored only when enable bit i is set. The other bytes of the word keep their contents.
- R9: A granted write updates the bank at the clock edge that ends its grant cycle, so a read granted in the next cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_blocked | input | 1 | 1 selects the blocked map, 0 the interleaved map |
| m_req | input | N_MASTERS | Request, one bit per master |
| m_we | input | N_MASTERS | 1 marks a write, 0 a read |
| m_addr | input | N_MASTERS*10 | Word address; master m uses bits [10m+9:10m] |
| m_wdata | input | N_MASTERS*32 | Write data, 32 bits per master |
| m_be | input | N_MASTERS*4 | Byte enables, 4 bits per master |
| m_gnt | output | N_MASTERS | Grant in the current cycle, one bit per master |
| m_rvalid | output | N_MASTERS | Read data valid, one bit per master |
| m_rdata | output | N_MASTERS*32 | Read data, 32 bits per master |

## Verification
The tests set up several distinct patterns:
- A single master writing and reading alone shows the basic timing.
- Two masters on addresses 1 and 2 contend only in the blocked map. This separates the two bank decodes.
- A word is written through one map and read through the other, which confirms that both maps land on the same physical storage.
- Three masters hold requests on one bank, which exposes the rotation order and the wrap past the last master index.
- Sixteen masters hit sixteen different banks at once, which shows the banks do not interfere.
- Partial byte-enable writes show lane masking.

// File: rtl/banked_mem_arbiter.sv
module banked_mem_arbiter #(
  parameter int N_MASTERS  = 20,
  parameter int N_BANKS    = 16,
  parameter int BANK_WORDS = 64,
  parameter int DATA_W     = 32,
  localparam int BB  = $clog2(N_BANKS),
  localparam int RW  = $clog2(BANK_WORDS),
  localparam int AW  = BB + RW,
  localparam int BEW = DATA_W / 8,
  localparam int MW  = $clog2(N_MASTERS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_blocked,
  input  logic [N_MASTERS-1:0]      m_req,
  input  logic [N_MASTERS-1:0]      m_we,
  input  logic [N_MASTERS*AW-1:0]   m_addr,
  input  logic [N_MASTERS*DATA_W-1:0] m_wdata,
  input  logic [N_MASTERS*BEW-1:0]  m_be,
  output logic [N_MASTERS-1:0]      m_gnt,
  output logic [N_MASTERS-1:0]      m_rvalid,
  output logic [N_MASTERS*DATA_W-1:0] m_rdata
);

  logic [BB-1:0]     bank_of [N_MASTERS];
  logic [RW-1:0]     row_of  [N_MASTERS];
  logic [MW-1:0]     ptr     [N_BANKS];
  logic [MW-1:0]     win     [N_BANKS];
  logic [N_BANKS-1:0] bvalid;
  logic [DATA_W-1:0] mem     [N_BANKS][BANK_WORDS];
  logic [DATA_W-1:0] rdata_q [N_MASTERS];

  always_comb begin
    for (int m = 0; m < N_MASTERS; m++) begin
      if (mode_blocked) begin
        bank_of[m] = m_addr[m*AW + RW +: BB];
        row_of[m]  = m_addr[m*AW +: RW];
      end else begin
        bank_of[m] = m_addr[m*AW +: BB];
        row_of[m]  = m_addr[m*AW + BB +: RW];
      end
    end
  end

  always_comb begin
    m_gnt = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      win[b]    = '0;
      bvalid[b] = 1'b0;
      for (int k = 0; k < N_MASTERS; k++) begin
        int idx;
        idx = int'(ptr[b]) + k;
        if (idx >= N_MASTERS) idx = idx - N_MASTERS;
        if (!bvalid[b] && m_req[idx] && bank_of[idx] == BB'(b)) begin
          bvalid[b] = 1'b1;
          win[b]    = MW'(idx);
        end
      end
      if (bvalid[b]) m_gnt[win[b]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < N_BANKS; b++) ptr[b] <= '0;
      m_rvalid <= '0;
    end else begin
      for (int b = 0; b < N_BANKS; b++)
        if (bvalid[b])
          ptr[b] <= (int'(win[b]) == N_MASTERS-1) ? '0 : win[b] + MW'(1);
      m_rvalid <= m_gnt & ~m_we;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < N_BANKS; b++) begin
      if (bvalid[b]) begin
        if (m_we[win[b]]) begin
          for (int i = 0; i < BEW; i++)
            if (m_be[int'(win[b])*BEW + i])
              mem[b][row_of[win[b]]][8*i +: 8] <= m_wdata[int'(win[b])*DATA_W + 8*i +: 8];
        end else begin
          rdata_q[win[b]] <= mem[b][row_of[win[b]]];
        end
      end
    end
  end

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_ret
    assign m_rdata[m*DATA_W +: DATA_W] = rdata_q[m];

    // R4
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_gnt[m] |-> m_req[m]);

    // R7
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_gnt[m] && !m_we[m]) |=> m_rvalid[m]);

    // R7
    rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_rvalid[m] |-> $past(m_gnt[m] && !m_we[m]));
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bchk
    logic [N_MASTERS-1:0] hits;
    always_comb
      for (int m = 0; m < N_MASTERS; m++)
        hits[m] = m_gnt[m] && (bank_of[m] == BB'(b));

    // R4
    one_grant_per_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hits));
  end

endmodule

// File: tb/banked_mem_arbiter_tb.sv
`timescale 1ns/1ps
module banked_mem_arbiter_tb_top;
  localparam int N = 20;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, mode_blocked = 0;
  logic [N-1:0] m_req = '0, m_we = '0;
  logic [N*AW-1:0] m_addr = '0;
  logic [N*32-1:0] m_wdata = '0;
  logic [N*4-1:0] m_be = '0;
  logic [N-1:0] m_gnt, m_rvalid;
  logic [N*32-1:0] m_rdata;
  int checks = 0, errors = 0;

  banked_mem_arbiter dut_i (.clk, .rst_n, .mode_blocked, .m_req, .m_we, .m_addr,
    .m_wdata, .m_be, .m_gnt, .m_rvalid, .m_rdata);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask
  task automatic idle_all; m_req = '0; m_we = '0; endtask
  task automatic drive(input int m, input bit we, input int addr, input logic [31:0] d, input logic [3:0] be);
    m_req[m] = 1; m_we[m] = we; m_addr[m*AW +: AW] = AW'(addr);
    m_wdata[m*32 +: 32] = d; m_be[m*4 +: 4] = be;
  endtask
  function automatic logic [31:0] rd(input int m); return m_rdata[m*32 +: 32]; endfunction

  task automatic t_reset;
    #1;
    chk(m_rvalid == '0, "R1 rvalid after reset", 64'(m_rvalid), 0);
    chk(m_gnt == '0, "R1 no grant when idle", 64'(m_gnt), 0);
  endtask

  task automatic t_rw;
    mode_blocked = 0; idle_all();
    drive(0, 1, 5, 32'hA5A51234, 4'hF); #1;
    chk(m_gnt == N'(1), "R9 write grant", 64'(m_gnt), 1);
    tick();
    chk(m_rvalid == '0, "R7 no rvalid for write", 64'(m_rvalid), 0);
    idle_all(); drive(0, 0, 5, 0, 0); tick();
    chk(m_rvalid[0] && rd(0) == 32'hA5A51234, "R9 read after write", 64'(rd(0)), 64'hA5A51234);
    idle_all(); tick();
    chk(m_rvalid == '0, "R7 rvalid drops", 64'(m_rvalid), 0);
  endtask

  task automatic t_map;
    mode_blocked = 0; idle_all();
    drive(1, 1, 1, 32'h11111111, 4'hF); drive(2, 1, 2, 32'h22222222, 4'hF); #1;
    chk(m_gnt == N'(6), "R2 addr 1,2 distinct banks", 64'(m_gnt), 6);
    tick();
    mode_blocked = 1; idle_all();
    drive(1, 0, 1, 0, 0); drive(2, 0, 2, 0, 0); #1;
    chk(m_gnt == N'(2), "R3 addr 1,2 share bank 0", 64'(m_gnt), 2);
    tick();
    idle_all(); drive(1, 0, 64, 0, 0); drive(2, 0, 128, 0, 0); tick();
    chk(m_rvalid[1] && rd(1) == 32'h11111111, "R3 blocked 64 = bank1 row0", 64'(rd(1)), 64'h11111111);
    chk(m_rvalid[2] && rd(2) == 32'h22222222, "R3 blocked 128 = bank2 row0", 64'(rd(2)), 64'h22222222);
    idle_all(); drive(4, 1, 193, 32'hCAFE0003, 4'hF); tick();
    mode_blocked = 0; idle_all(); drive(4, 0, 19, 0, 0); tick();
    chk(m_rvalid[4] && rd(4) == 32'hCAFE0003, "R2 interleaved 19 = bank3 row1", 64'(rd(4)), 64'hCAFE0003);
    idle_all();
  endtask

  task automatic t_rr;
    int exp_seq[4] = '{3, 10, 19, 3};
    mode_blocked = 0; idle_all();
    drive(3, 0, 7, 0, 0); drive(10, 0, 7, 0, 0); drive(19, 0, 7, 0, 0);
    foreach (exp_seq[i]) begin
      #1;
      chk(m_gnt == (N'(1) << exp_seq[i]), "R5 round-robin order", 64'(m_gnt), 64'(N'(1) << exp_seq[i]));
      chk($countones(m_gnt) <= 1, "R4 one grant per bank", 64'($countones(m_gnt)), 1);
      tick();
    end
    idle_all();
  endtask

  task automatic t_ind;
    mode_blocked = 0; idle_all();
    for (int m = 0; m < 16; m++) drive(m, 1, m, 32'h1000 + m, 4'hF);
    #1;
    chk(m_gnt == N'(16'hFFFF), "R6 parallel writes", 64'(m_gnt), 64'hFFFF);
    tick();
    idle_all();
    for (int m = 0; m < 16; m++) drive(m, 0, 15 - m, 0, 0);
    #1;
    chk(m_gnt == N'(16'hFFFF), "R6 parallel reads", 64'(m_gnt), 64'hFFFF);
    tick();
    chk(m_rvalid == N'(16'hFFFF), "R7 parallel rvalid", 64'(m_rvalid), 64'hFFFF);
    for (int m = 0; m < 16; m++)
      chk(rd(m) == 32'h1000 + 15 - m, "R6 parallel read data", 64'(rd(m)), 64'(32'h1000 + 15 - m));
    idle_all();
  endtask

  task automatic t_be;
    mode_blocked = 0; idle_all();
    drive(5, 1, 40, 32'hFFFFFFFF, 4'hF); tick();
    idle_all(); drive(5, 1, 40, 32'h00000000, 4'b0101); tick();
    idle_all(); drive(5, 0, 40, 0, 0); tick();
    chk(m_rvalid[5] && rd(5) == 32'hFF00FF00, "R8 byte enables", 64'(rd(5)), 64'hFF00FF00);
    idle_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    @(negedge clk);
    t_rr();
    t_rw();
    t_map();
    t_ind();
    t_be();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule